// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the 32-bit control and status word of a floating-point unit and keeps it current. Software loads the word through a write strobe. The arithmetic pipeline sends one report per completed operation, a vector of exception kinds, and the block turns it into cause bits, sticky flags and a trap request. Compare instructions set individual condition codes by index. An issue strobe from the instruction sequencer advances a two-deep history of condition code 0, so that branch logic can look at the value that code 0 had one instruction earlier.

The condition codes do not occupy a contiguous field. Code 0 sits below the flush-to-zero bit, and codes 1 and up sit above it. A parameter sets how many codes exist. When it is set to one, the upper code bits are absent: they read as zero and cannot be written.

Top module: `fcsr_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `csr_q` is zero, `trap` is low and `cc0_prev` is low.
- R2: A cycle with `sw_we` high loads `sw_wdata` into `csr_q` at the next edge. Bits 22:18 are always stored as zero. With NUM_CC=8 every other bit is stored. With NUM_CC=1 bits 31:25 are also stored as zero.
- R3: `round_mode` is `csr_q[1:0]` (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf). `flush_zero` is `csr_q[24]`.
- R4: A cycle with `cc_set` high writes `cc_val` into one bit: bit 23 for index 0, and bit 24+n for index n≥1. No other bit changes. `cc_bits[n]` reports that same bit.
- R5: Exception kinds are numbered inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4, unimplemented 5, and `op_kinds[k]` carries kind k. A report (`op_valid`) overwrites cause field 17:12 with `op_kinds`, with kind k placed at bit 12+k.
- R6: If a report does not trap, kinds 0 to 4 are ORed into the sticky flags at bits 6:2, with kind k placed at bit 2+k. The unimplemented kind has no flag bit.
- R7: `trap` rises for exactly the cycle after a report whose kinds include an enabled kind or the unimplemented kind. The enable for kind k (k≤4) is bit 7+k. A trapping report leaves the flags unchanged.
- R8: If `sw_we` and `op_valid` are high in the same cycle, the software word is stored, the report is discarded and `trap` stays low.
- R9: On each `issue` pulse, the previous shadow takes the value of the current shadow, and the current shadow takes `csr_q[23]` as it stood before that edge. `cc0_prev` shows the previous shadow, and both shadows hold their value between pulses.
- R10: With NUM_CC=1, a condition-code set with a nonzero index changes nothing, and `cc_bits[7:1]` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| op_valid | input | 1 | Operation report strobe |
| op_kinds | input | 6 | Exception kinds raised by the reported operation |
| cc_set | input | 1 | Condition-code set strobe |
| cc_idx | input | 3 | Index of the condition code to set |
| cc_val | input | 1 | Value to write into the condition code |
| issue | input | 1 | Instruction-issue strobe |
| csr_q | output | 32 | Full register value |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| cc_bits | output | 8 | Condition codes, index order |
| cc0_prev | output | 1 | Code 0 as sampled one issue earlier |
| trap | output | 1 | Floating-point trap request |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. One copy uses NUM_CC=8, which covers the split code field, the hole at bit 24 and the upper code bits. The other uses NUM_CC=1, which covers the masked upper bits and the sets that must be ignored. Between them they show that the same write or set gives different stored words depending only on the parameter. The tests also cover the issue history in the case where a code-0 set and an issue land in the same cycle.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int CSR_W       = 32;
  localparam int KINDS       = 6;   // exception kinds incl. unimplemented
  localparam int TRAPPABLE   = 5;   // kinds that own a flag and an enable
  localparam int MAX_CC      = 8;
  localparam int CC_IDX_W    = $clog2(MAX_CC);
  localparam int RM_LSB      = 0;
  localparam int FLAG_LSB    = 2;
  localparam int EN_LSB      = 7;
  localparam int CAUSE_LSB   = 12;
  localparam int CC0_POS     = 23;
  localparam int FZ_POS      = 24;
  localparam int CC_UP_BASE  = 24;  // code n>=1 lives at CC_UP_BASE+n

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_UP      = 2'd2,
    RND_DOWN    = 2'd3
  } rnd_mode_t;

  function automatic int cc_pos(input int n);
    return (n == 0) ? CC0_POS : CC_UP_BASE + n;
  endfunction

  function automatic logic [CSR_W-1:0] store_mask(input int ncc);
    logic [CSR_W-1:0] m;
    m = '0;
    m[1:0] = '1;
    m[FLAG_LSB +: TRAPPABLE]  = '1;
    m[EN_LSB +: TRAPPABLE]    = '1;
    m[CAUSE_LSB +: KINDS]     = '1;
    m[FZ_POS] = 1'b1;
    for (int n = 0; n < MAX_CC; n++)
      if (n < ncc) m[cc_pos(n)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fcsr_exc_merge.sv
module fcsr_exc_merge
  import fcsr_pkg::*;
(
  input  logic [CSR_W-1:0]     csr_cur,
  input  logic [KINDS-1:0]     kinds,
  output logic [KINDS-1:0]     cause_nxt,
  output logic [TRAPPABLE-1:0] flags_nxt,
  output logic                 trap_nxt
);
  logic [TRAPPABLE-1:0] enables;
  logic [TRAPPABLE-1:0] flags_old;
  logic                 hit_enabled;

  assign enables     = csr_cur[EN_LSB +: TRAPPABLE];
  assign flags_old   = csr_cur[FLAG_LSB +: TRAPPABLE];
  assign hit_enabled = |(kinds[TRAPPABLE-1:0] & enables);

  always_comb begin
    cause_nxt = kinds;
    trap_nxt  = hit_enabled | kinds[KINDS-1];
    flags_nxt = trap_nxt ? flags_old : (flags_old | kinds[TRAPPABLE-1:0]);
  end
endmodule

// File: rtl/fcsr_cc_field.sv
module fcsr_cc_field
  import fcsr_pkg::*;
#(
  parameter int NUM_CC = 8
) (
  input  logic [CSR_W-1:0]    csr_cur,
  input  logic                cc_set,
  input  logic [CC_IDX_W-1:0] cc_idx,
  input  logic                cc_val,
  output logic [CSR_W-1:0]    csr_upd,
  output logic [MAX_CC-1:0]   cc_view
);
  for (genvar n = 0; n < MAX_CC; n++) begin : g_view
    if (n < NUM_CC) begin : g_live
      assign cc_view[n] = csr_cur[cc_pos(n)];
    end else begin : g_dead
      assign cc_view[n] = 1'b0;
    end
  end

  always_comb begin
    csr_upd = csr_cur;
    for (int n = 0; n < NUM_CC; n++)
      if (cc_set && (cc_idx == CC_IDX_W'(n)))
        csr_upd[cc_pos(n)] = cc_val;
  end
endmodule

// File: rtl/fcsr_cc_history.sv
module fcsr_cc_history (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic cc0_now,
  output logic cur_q,
  output logic prev_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (issue) begin
      prev_q <= cur_q;
      cur_q  <= cc0_now;
    end
  end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
#(
  parameter int NUM_CC = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_we,
  input  logic [31:0] sw_wdata,
  input  logic        op_valid,
  input  logic [5:0]  op_kinds,
  input  logic        cc_set,
  input  logic [2:0]  cc_idx,
  input  logic        cc_val,
  input  logic        issue,
  output logic [31:0] csr_q,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic [7:0]  cc_bits,
  output logic        cc0_prev,
  output logic        trap
);
  localparam logic [CSR_W-1:0] MASK = store_mask(NUM_CC);

  logic [CSR_W-1:0]     csr_r;
  logic [CSR_W-1:0]     csr_cc;
  logic [CSR_W-1:0]     csr_d;
  logic [KINDS-1:0]     cause_nxt;
  logic [TRAPPABLE-1:0] flags_nxt;
  logic                 trap_nxt;
  logic                 trap_r;
  logic                 cc0_cur;
  logic                 take_op;

  fcsr_cc_field #(.NUM_CC(NUM_CC)) u_cc (
    .csr_cur (csr_r),
    .cc_set  (cc_set),
    .cc_idx  (cc_idx),
    .cc_val  (cc_val),
    .csr_upd (csr_cc),
    .cc_view (cc_bits)
  );

  fcsr_exc_merge u_exc (
    .csr_cur   (csr_r),
    .kinds     (op_kinds),
    .cause_nxt (cause_nxt),
    .flags_nxt (flags_nxt),
    .trap_nxt  (trap_nxt)
  );

  fcsr_cc_history u_hist (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue),
    .cc0_now (csr_r[CC0_POS]),
    .cur_q   (cc0_cur),
    .prev_q  (cc0_prev)
  );

  assign take_op = op_valid && !sw_we;

  always_comb begin
    csr_d = csr_cc;
    if (take_op) begin
      csr_d[CAUSE_LSB +: KINDS]    = cause_nxt;
      csr_d[FLAG_LSB +: TRAPPABLE] = flags_nxt;
    end
    if (sw_we)
      csr_d = sw_wdata & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_r  <= '0;
      trap_r <= 1'b0;
    end else begin
      csr_r  <= csr_d;
      trap_r <= take_op && trap_nxt;
    end
  end

  assign csr_q      = csr_r;
  assign round_mode = csr_r[RM_LSB +: 2];
  assign flush_zero = csr_r[FZ_POS];
  assign trap       = trap_r;
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk #(
  parameter int NUM_CC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        sw_we,
  input logic        op_valid,
  input logic [5:0]  op_kinds,
  input logic        issue,
  input logic [31:0] csr_q,
  input logic        cc0_cur,
  input logic        cc0_prev,
  input logic        trap
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    csr_q[22:18] == 5'd0);

  assert_cause_load_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sw_we) |=> csr_q[17:12] == $past(op_kinds));

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sw_we) |=> ((csr_q[6:2] & $past(csr_q[6:2])) == $past(csr_q[6:2])));

  assert_trap_source_R7: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(op_valid && !sw_we));

  assert_sw_wins_R8: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> !trap);

  assert_hist_shift_R9: assert property (@(posedge clk) disable iff (rst)
    issue |=> (cc0_prev == $past(cc0_cur)) && (cc0_cur == $past(csr_q[23])));

  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(cc0_prev) && $stable(cc0_cur));

  if (NUM_CC == 1) begin : g_one
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
      csr_q[31:25] == 7'd0);
  end
endmodule

bind fcsr_unit fcsr_unit_chk #(.NUM_CC(NUM_CC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sw_we    (sw_we),
  .op_valid (op_valid),
  .op_kinds (op_kinds),
  .issue    (issue),
  .csr_q    (csr_q),
  .cc0_cur  (cc0_cur),
  .cc0_prev (cc0_prev),
  .trap     (trap)
);

// File: tb/tb_fcsr_unit.sv
module tb_fcsr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        sw_we;
  logic [31:0] sw_wdata;
  logic        op_valid;
  logic [5:0]  op_kinds;
  logic        cc_set;
  logic [2:0]  cc_idx;
  logic        cc_val;
  logic        issue;

  logic [31:0] csr8, csr1;
  logic [1:0]  rm8, rm1;
  logic        fz8, fz1;
  logic [7:0]  cc8, cc1;
  logic        pv8, pv1;
  logic        tr8, tr1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fcsr_unit #(.NUM_CC(8)) dut (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .op_valid(op_valid), .op_kinds(op_kinds), .cc_set(cc_set),
    .cc_idx(cc_idx), .cc_val(cc_val), .issue(issue),
    .csr_q(csr8), .round_mode(rm8), .flush_zero(fz8), .cc_bits(cc8),
    .cc0_prev(pv8), .trap(tr8)
  );

  fcsr_unit #(.NUM_CC(1)) dut_one (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .op_valid(op_valid), .op_kinds(op_kinds), .cc_set(cc_set),
    .cc_idx(cc_idx), .cc_val(cc_val), .issue(issue),
    .csr_q(csr1), .round_mode(rm1), .flush_zero(fz1), .cc_bits(cc1),
    .cc0_prev(pv1), .trap(tr1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sw_we = 0; sw_wdata = 0; op_valid = 0; op_kinds = 0;
    cc_set = 0; cc_idx = 0; cc_val = 0; issue = 0;
  endtask

  // inputs change at negedge; one posedge later, sampled at the next negedge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic sw_write(input logic [31:0] d);
    sw_we = 1; sw_wdata = d; tick();
  endtask

  task automatic report(input logic [5:0] k);
    op_valid = 1; op_kinds = k; tick();
  endtask

  task automatic set_cc(input logic [2:0] i, input logic v);
    cc_set = 1; cc_idx = i; cc_val = v; tick();
  endtask

  task automatic pulse_issue();
    issue = 1; tick();
  endtask

  task automatic t_reset();
    rst = 1; idle();
    repeat (3) @(negedge clk);
    chk("R1 csr in reset", csr8, 32'h0);
    rst = 0;
    @(negedge clk);
    chk("R1 csr after reset", csr8, 32'h0);
    chk("R1 csr one-code after reset", csr1, 32'h0);
    chk("R1 trap/prev after reset", {30'd0, tr8, pv8}, 32'h0);
  endtask

  task automatic t_write();
    sw_write(32'hFFFF_FFFF);
    chk("R2 all-ones eight codes", csr8, 32'hFF83_FFFF);
    chk("R2 all-ones one code", csr1, 32'h0183_FFFF);
    chk("R3 rm all-ones", {30'd0, rm8}, 32'd3);
    chk("R3 fz all-ones", {31'd0, fz8}, 32'd1);
    chk("R4 cc view eight", {24'd0, cc8}, 32'hFF);
    chk("R10 cc view one", {24'd0, cc1}, 32'h01);
    sw_write(32'h0000_0002);
    chk("R3 rm toward +inf", {30'd0, rm8}, 32'd2);
    chk("R3 fz cleared", {31'd0, fz8}, 32'd0);
    sw_write(32'h0100_0001);
    chk("R3 rm toward zero", {30'd0, rm1}, 32'd1);
    chk("R3 fz set", {31'd0, fz1}, 32'd1);
  endtask

  task automatic t_cc();
    sw_write(32'h0);
    set_cc(3'd3, 1'b1);
    chk("R4 code 3 at bit 27", csr8, 32'h0800_0000);
    chk("R10 code 3 ignored", csr1, 32'h0);
    set_cc(3'd0, 1'b1);
    chk("R4 code 0 at bit 23", csr8, 32'h0880_0000);
    chk("R4 code 0 one-code", csr1, 32'h0080_0000);
    set_cc(3'd3, 1'b0);
    chk("R4 clear code 3 only", csr8, 32'h0080_0000);
    set_cc(3'd1, 1'b1);
    chk("R4 code 1 at bit 25, fz untouched", csr8, 32'h0280_0000);
    chk("R4 fz stays low", {31'd0, fz8}, 32'd0);
    chk("R10 cc view one-code", {24'd0, cc1}, 32'h01);
  endtask

  task automatic t_report();
    sw_write(32'h0);
    report(6'b000101);
    chk("R5 R6 inexact+overflow", csr8, 32'h0000_5014);
    chk("R7 no trap when disabled", {31'd0, tr8}, 32'd0);
    report(6'b000010);
    chk("R5 R6 cause replaced, flags or", csr8, 32'h0000_201C);
    report(6'b100000);
    chk("R7 unimplemented traps", {31'd0, tr8}, 32'd1);
    chk("R6 R7 flags kept on trap", csr8, 32'h0002_001C);
    tick();
    chk("R7 trap one cycle", {31'd0, tr8}, 32'd0);
    sw_write(32'h0000_0400);
    report(6'b001000);
    chk("R7 enabled divide traps", {31'd0, tr1}, 32'd1);
    chk("R7 flag not set on trap", csr1, 32'h0000_8400);
    report(6'b000001);
    chk("R7 disabled inexact no trap", {31'd0, tr8}, 32'd0);
    chk("R6 inexact flagged", csr8, 32'h0000_1404);
  endtask

  task automatic t_priority();
    sw_write(32'h0000_0F80);
    sw_we = 1; sw_wdata = 32'h0000_0003; op_valid = 1; op_kinds = 6'h3F;
    tick();
    chk("R8 software word wins", csr8, 32'h0000_0003);
    chk("R8 no trap", {31'd0, tr8}, 32'd0);
  endtask

  task automatic t_history();
    sw_write(32'h0);
    pulse_issue(); pulse_issue();
    chk("R9 prev low", {31'd0, pv8}, 32'd0);
    set_cc(3'd0, 1'b1);
    pulse_issue();
    chk("R9 A prev still 0", {31'd0, pv8}, 32'd0);
    pulse_issue();
    chk("R9 B prev now 1", {31'd0, pv8}, 32'd1);
    repeat (3) tick();
    chk("R9 prev holds without issue", {31'd0, pv1}, 32'd1);
    set_cc(3'd0, 1'b0);
    pulse_issue();
    chk("R9 C prev 1", {31'd0, pv8}, 32'd1);
    pulse_issue();
    chk("R9 D prev 0", {31'd0, pv8}, 32'd0);
    cc_set = 1; cc_idx = 0; cc_val = 1; issue = 1;
    tick();
    pulse_issue();
    chk("R9 same-cycle set uses old bit", {31'd0, pv8}, 32'd0);
    pulse_issue();
    chk("R9 new bit arrives one issue later", {31'd0, pv1}, 32'd1);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_cc();
    t_report();
    t_priority();
    t_history();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule